// File: doc/BRIEF.md
# Indexed Codec Register File

This block is the host-visible control register space of an audio codec that sits behind a DMA front end. A host talks to it over a plain synchronous bus. Each access carries a 6-bit byte address. A write strobe comes with 32-bit write data, and a read strobe returns 32-bit read data. Bits [5:2] of the address pick one of sixteen 32-bit direct words. Most of these words are ordinary storage. One direct word holds an index, and a second direct word is a data window onto a bank of thirty-two 8-bit indirect registers, so the index selects which indirect register the window reaches.

Several words and indices follow special rules. One direct word always reads zero. The control word clears its upper bits, and writing it with bit 0 set performs a soft reset. One indirect register can be written but always reads back zero. Two indirect registers hold fixed values. One indirect register keeps a single writable bit and holds a fixed version code in its other bits. Read data is combinational from the address and the strobe. Writes take effect on the rising clock edge. A synchronous active-high reset loads the same values that the soft reset loads.

Top module: `codec_regfile`

## Requirements
- R1: After reset every direct word reads 0. Every indirect register reads 0, except index 12, which reads 0x8A, and index 25, which reads 0xA0.
- R2: A write to direct word 0, 3 or 5..15 stores all 32 data bits, and a read of that word returns them. Byte-address bits [1:0] are ignored.
- R3: The low 5 bits of direct word 0 select the indirect register; the upper bits of word 0 do not affect the selection. A write to direct word 1 stores wr_data[7:0] into the selected indirect register. A read of word 1 returns that register zero-extended to 32 bits.
- R4: A read of indirect index 3 through word 1 returns 0, even after a nonzero write to that index.
- R5: Writes to indirect indices 11 and 25 have no effect. Index 11 keeps reading 0 and index 25 keeps reading 0xA0.
- R6: A write of value d to indirect index 12 stores (d & 0x40) | 0x8A.
- R7: Direct word 2 always reads 0 and ignores writes.
- R8: A write to direct word 4 stores wr_data & 0x7F. When wr_data bit 0 is 1, every other direct word and every indirect register first returns to its R1 value in the same edge. When bit 0 is 0, nothing else changes.
- R9: While rd_en is low, rd_data is 0.
- R10: rd_data is valid in the same cycle as rd_en, and a write shows up on a read in the cycle after its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes act on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address; bits [5:2] select the direct word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational; 0 when rd_en is low |

## Verification
Read data is due in the same cycle as the read strobe, with no register in the path. The bench raises rd_en and the address on a falling edge and samples rd_data 1 ns later, well before the next rising edge. A write is due one rising edge after its strobe. The bench therefore holds wr_en from one falling edge to the next and reads back only after that rising edge has passed. A soft reset and its masked store to the control word land on the same edge, so a single read pass afterwards sees both results.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = ADDR_W - 2;
    localparam int DIR_WORDS = 1 << SEL_W;
    localparam int IND_W     = 8;
    localparam int IDX_W     = 5;
    localparam int IND_REGS  = 1 << IDX_W;

    localparam logic [SEL_W-1:0] W_INDEX  = SEL_W'(0);
    localparam logic [SEL_W-1:0] W_WINDOW = SEL_W'(1);
    localparam logic [SEL_W-1:0] W_STATUS = SEL_W'(2);
    localparam logic [SEL_W-1:0] W_CTRL   = SEL_W'(4);

    localparam logic [IDX_W-1:0] I_HIDDEN = IDX_W'(3);
    localparam logic [IDX_W-1:0] I_LOCKED = IDX_W'(11);
    localparam logic [IDX_W-1:0] I_VER    = IDX_W'(12);
    localparam logic [IDX_W-1:0] I_ID     = IDX_W'(25);

    localparam logic [IND_W-1:0]  CODEC_VER = 8'h8A;
    localparam logic [IND_W-1:0]  CHIP_ID   = 8'hA0;
    localparam logic [IND_W-1:0]  VER_KEEP  = 8'h40;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_007F;

    typedef enum logic [1:0] {
        WK_PLAIN,
        WK_WINDOW,
        WK_RDONLY,
        WK_CTRL
    } word_kind_e;

    typedef struct packed {
        logic [SEL_W-1:0]  word;
        logic              dir_we;
        logic              ind_we;
        logic              soft_rst;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic word_kind_e kind_of(input logic [SEL_W-1:0] w);
        case (w)
            W_WINDOW: return WK_WINDOW;
            W_STATUS: return WK_RDONLY;
            W_CTRL:   return WK_CTRL;
            default:  return WK_PLAIN;
        endcase
    endfunction

    function automatic logic [IND_W-1:0] ind_reset_val(input logic [IDX_W-1:0] i);
        if (i == I_VER) return CODEC_VER;
        if (i == I_ID)  return CHIP_ID;
        return '0;
    endfunction

    function automatic logic ind_writable(input logic [IDX_W-1:0] i);
        return (i != I_LOCKED) && (i != I_ID);
    endfunction

    function automatic logic ind_readable(input logic [IDX_W-1:0] i);
        return i != I_HIDDEN;
    endfunction

    function automatic logic [IND_W-1:0] ind_store_val(input logic [IDX_W-1:0] i,
                                                       input logic [IND_W-1:0] d);
        if (i == I_VER) return (d & VER_KEEP) | CODEC_VER;
        return d;
    endfunction

endpackage

// File: rtl/codec_bus_decode.sv
module codec_bus_decode
    import codec_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output bus_req_t          req
);
    word_kind_e kind;

    always_comb begin
        req.word     = addr[ADDR_W-1:2];
        kind         = kind_of(req.word);
        req.dir_we   = wr_en && (kind == WK_PLAIN || kind == WK_CTRL);
        req.ind_we   = wr_en && (kind == WK_WINDOW);
        req.soft_rst = wr_en && (kind == WK_CTRL) && wr_data[0];
        req.data     = wr_data;
    end

    logic unused_low;
    assign unused_low = ^addr[1:0];
endmodule

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [DATA_W-1:0] words_o [DIR_WORDS]
);
    for (genvar w = 0; w < DIR_WORDS; w++) begin : g_word
        localparam word_kind_e KIND = kind_of(SEL_W'(w));
        if (KIND == WK_WINDOW || KIND == WK_RDONLY) begin : g_none
            assign words_o[w] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (req.dir_we && req.word == SEL_W'(w)) begin
                    q <= (KIND == WK_CTRL) ? (req.data & CTRL_MASK) : req.data;
                end else if (req.soft_rst) begin
                    q <= '0;
                end
            end
            assign words_o[w] = q;
        end
    end
endmodule

// File: rtl/codec_indirect_bank.sv
module codec_indirect_bank
    import codec_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [IND_W-1:0] wdata,
    output logic [IND_W-1:0] regs_o [IND_REGS]
);
    for (genvar i = 0; i < IND_REGS; i++) begin : g_reg
        localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
        if (!ind_writable(IDX)) begin : g_fixed
            assign regs_o[i] = ind_reset_val(IDX);
        end else begin : g_store
            logic [IND_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    q <= ind_reset_val(IDX);
                end else if (we && idx == IDX) begin
                    q <= ind_store_val(IDX, wdata);
                end
            end
            assign regs_o[i] = q;
        end
    end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data
);
    bus_req_t          req;
    logic [DATA_W-1:0] dir_words [DIR_WORDS];
    logic [IND_W-1:0]  ind_bytes [IND_REGS];
    logic [IDX_W-1:0]  ind_index;
    logic [DATA_W-1:0] rd_mux;

    codec_bus_decode u_decode (
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req     (req)
    );

    codec_direct_bank u_direct (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .words_o (dir_words)
    );

    assign ind_index = dir_words[W_INDEX][IDX_W-1:0];

    codec_indirect_bank u_indirect (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (req.soft_rst),
        .we       (req.ind_we),
        .idx      (ind_index),
        .wdata    (req.data[IND_W-1:0]),
        .regs_o   (ind_bytes)
    );

    always_comb begin
        rd_mux = dir_words[req.word];
        if (kind_of(req.word) == WK_WINDOW) begin
            rd_mux = ind_readable(ind_index) ? DATA_W'(ind_bytes[ind_index]) : '0;
        end
    end

    assign rd_data = rd_en ? rd_mux : '0;

    logic unused_upper;
    assign unused_upper = ^dir_words[W_INDEX][DATA_W-1:IDX_W];
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic [5:0]  addr,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [4:0]  index_q,
    input logic [31:0] word5_q,
    input logic [31:0] ctrl_q
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == 32'h0); // R9

    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[5:2] == 4'd2) |-> rd_data == 32'h0); // R7

    AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[5:2] == 4'd1 && index_q == 5'd3) |-> rd_data == 32'h0); // R4

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[5:2] == 4'd1 && index_q == 5'd25) |-> rd_data == 32'hA0); // R5

    AST_VER_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[5:2] == 4'd1 && index_q == 5'd12)
        |-> (rd_data & ~32'h40) == 32'h8A); // R6

    AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[5:2] == 4'd5) |=> word5_q == $past(wr_data)); // R2

    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[5:2] == 4'd4) |=> ctrl_q == ($past(wr_data) & 32'h7F)); // R8

    AST_SOFT_CLEARS_INDEX: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[5:2] == 4'd4 && wr_data[0]) |=> index_q == 5'd0); // R8
endmodule

bind codec_regfile codec_regfile_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .index_q (ind_index),
    .word5_q (dir_words[5]),
    .ctrl_q  (dir_words[4])
);

// File: tb/tb_codec_regfile.sv
`timescale 1ns/1ps
module tb_codec_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] dir_m [16];
    logic [7:0]  ind_m [32];

    codec_regfile dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic model_reset();
        for (int w = 0; w < 16; w++) dir_m[w] = '0;
        for (int i = 0; i < 32; i++) ind_m[i] = 8'h00;
        ind_m[12] = 8'h8A;
        ind_m[25] = 8'hA0;
    endtask

    task automatic model_write(input logic [5:0] a, input logic [31:0] d);
        int w = int'(a[5:2]);
        int idx = int'(dir_m[0][4:0]);
        if (w == 1) begin
            if (idx == 12) ind_m[idx] = (d[7:0] & 8'h40) | 8'h8A;
            else if (idx != 11 && idx != 25) ind_m[idx] = d[7:0];
        end else if (w == 4) begin
            if (d[0]) model_reset();
            dir_m[4] = d & 32'h7F;
        end else if (w != 2) begin
            dir_m[w] = d;
        end
    endtask

    function automatic logic [31:0] model_read(input int w);
        int idx = int'(dir_m[0][4:0]);
        if (w == 2) return 32'h0;
        if (w == 1) return (idx == 3) ? 32'h0 : {24'h0, ind_m[idx]};
        return dir_m[w];
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read_check(input int w, input string tag);
        @(negedge clk);
        addr = 6'((w << 2) | (w & 3));
        rd_en = 1'b1;
        #1;
        check(rd_data, model_read(w), tag);
        rd_en = 1'b0;
    endtask

    task automatic read_indirect(input int i, input string tag);
        bus_write(6'd0, 32'hFFFF_FFE0 | 32'(i));
        bus_read_check(1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset values of all direct words and indirect registers
        for (int w = 0; w < 16; w++) bus_read_check(w, "R1");
        for (int i = 0; i < 32; i++) read_indirect(i, "R1");

        // R2, R7, R10: plain words keep all bits; word 2 stays zero
        for (int w = 0; w < 16; w++) begin
            if (w != 1 && w != 4) bus_write(6'((w << 2) | 3), 32'hA5C3_0000 ^ (32'(w) * 32'h0101_0101));
        end
        for (int w = 0; w < 16; w++) bus_read_check(w, "R2");
        bus_write(6'd8, 32'hDEAD_BEEF);
        bus_read_check(2, "R7");

        // R9: idle read strobe gives zero
        @(negedge clk);
        addr = 6'd12; rd_en = 1'b0; #1;
        check(rd_data, 32'h0, "R9");

        // R3, R4, R5, R6: write every index through the window, read all back
        for (int i = 0; i < 32; i++) begin
            bus_write(6'd0, 32'h1234_5600 | 32'(i));
            bus_write(6'd4 | 6'd2, 32'hABCD_EF00 | 32'((8'h5A ^ 8'(i * 7)) | 8'h01));
        end
        for (int i = 0; i < 32; i++) begin
            string t = (i == 3) ? "R4" : (i == 11 || i == 25) ? "R5" : (i == 12) ? "R6" : "R3";
            read_indirect(i, t);
        end

        // R6: version register keeps only bit 6
        bus_write(6'd0, 32'd12);
        bus_write(6'd4, 32'h0000_00FF);
        bus_read_check(1, "R6");
        bus_write(6'd4, 32'h0000_0000);
        bus_read_check(1, "R6");
        bus_write(6'd4, 32'h0000_0040);
        bus_read_check(1, "R6");

        // R8: control write with bit 0 clear leaves other state
        bus_write(6'd0, 32'd7);
        bus_write(6'd4, 32'h0000_0033);
        bus_write(6'd16, 32'hFFFF_FF80);
        for (int w = 0; w < 16; w++) bus_read_check(w, "R8");

        // R8: control write with bit 0 set resets then stores masked value
        bus_write(6'd17, 32'hFFFF_FFFF);
        for (int w = 0; w < 16; w++) bus_read_check(w, "R8");
        for (int i = 0; i < 32; i++) read_indirect(i, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule